// File: doc/BRIEF.md
# Binary XNOR-Popcount Neuron Array

This block evaluates one layer of a binarized neural network. Each activation and each weight is a single bit, where 1 stands for +1 and 0 stands for -1. A binary product is the XNOR of an activation bit and a weight bit. The dot product of a whole vector is taken as the number of agreeing bit positions (a popcount) rather than as a sum of signed products. Batch normalization and the sign activation are merged into one integer comparison per neuron, so each neuron yields a single output bit.

An activation vector of `VEC_BITS` bits enters over a valid/ready stream and is held in an input buffer. An array of `PE_COUNT` processing elements, each with `SIMD` XNOR lanes, works through the vector `SIMD` bits per cycle. The popcount accumulates across the `VEC_BITS/SIMD` folds, and the PE array is reused across `NEURONS/PE_COUNT` neuron groups. Each completed neuron bit is written into an output buffer. When every neuron is done, that buffer is offered on a second valid/ready stream. All weights and thresholds live in on-chip storage and are loaded through a plain write port.

The signed dot product equals 2*popcount - VEC_BITS. Each threshold entry therefore stores an integer level that is compared with the popcount directly. A polarity bit reverses the comparison, which covers a negative normalization scale.

Top module: `bnn_xnor_layer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A vector is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the result has been taken by `out_valid` and `out_ready` both being 1. It returns to 1 on the edge that follows that handshake. `in_ready` and `out_valid` are never 1 together.
- R3: With polarity 0, `out_vec[j]` is 1 exactly when popcount(XNOR(`in_vec`, weight row j)) >= level j. Equivalently, the ±1 dot product is at least 2*level - `VEC_BITS`. Weight row j fold f is written with `wt_row`=j and `wt_fold`=f. Bit i of `wt_bits` pairs with `in_vec[f*SIMD+i]`.
- R4: When the popcount equals the stored level exactly, the neuron outputs 1 for either polarity.
- R5: With polarity 1 (`th_invert`=1), `out_vec[j]` is 1 exactly when the popcount is <= level j.
- R6: `out_valid` rises on the clock edge exactly (NEURONS/PE_COUNT)*(VEC_BITS/SIMD) edges after the accepting edge. With the defaults this is 8.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_vec` does not change.
- R8: A vector presented on `in_valid` while the block is busy is not taken. The result of the vector already being processed is unaffected by it.
- R9: Weights and thresholds keep their values across vectors, so successive vectors are each evaluated against the loaded layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Activation vector offered |
| in_ready | output | 1 | Block can take a vector |
| in_vec | input | VEC_BITS | Activation bits, 1 = +1, 0 = -1 |
| out_valid | output | 1 | Output neuron vector available |
| out_ready | input | 1 | Consumer takes the output vector |
| out_vec | output | NEURONS | One bit per neuron, bit j = neuron j |
| wt_we | input | 1 | Write one weight fold |
| wt_row | input | log2(NEURONS) | Neuron row of the weight write |
| wt_fold | input | log2(VEC_BITS/SIMD) | Fold within the row |
| wt_bits | input | SIMD | Weight bits for that fold |
| th_we | input | 1 | Write one threshold entry |
| th_row | input | log2(NEURONS) | Neuron of the threshold write |
| th_level | input | clog2(VEC_BITS+1) | Popcount level |
| th_invert | input | 1 | Polarity: 1 compares popcount <= level |

## Verification
The only timed result is the output vector. It is due 8 edges after the accepting edge with the defaults, and `in_ready` returns one edge after the output handshake. The bench drives inputs on falling edges and counts falling edges from the accept. It requires `out_valid` to be low at each of the first seven and high at the eighth, and only then compares `out_vec` with a ±1 dot-product reference. The reference compares against 2*level - VEC_BITS. Backpressure and busy-time stimulus are checked at each falling edge while they are applied, and the return of `in_ready` is checked one falling edge after the output handshake.

// File: rtl/bnn_layer_pkg.sv
package bnn_layer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    // position of the current cycle inside a neuron's fold sequence
    typedef struct packed {
        logic first;
        logic last;
    } fold_step_t;

    // index width that never collapses to zero
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // folded normalization + sign: popcount against an integer level
    function automatic logic thr_fire(input logic [15:0] count,
                                      input logic [15:0] level,
                                      input logic        invert);
        return invert ? (count <= level) : (count >= level);
    endfunction

endpackage

// File: rtl/bnn_param_store.sv
module bnn_param_store
    import bnn_layer_pkg::*;
#(
    parameter int unsigned SIMD     = 8,
    parameter int unsigned NEURONS  = 8,
    parameter int unsigned PE_COUNT = 4,
    parameter int unsigned FOLDS    = 4,
    parameter int unsigned CNT_W    = 6,
    localparam int unsigned GROUPS  = NEURONS / PE_COUNT,
    localparam int unsigned ROW_W   = idx_w(NEURONS),
    localparam int unsigned FOLD_W  = idx_w(FOLDS),
    localparam int unsigned GRP_W   = idx_w(GROUPS)
) (
    input  logic                      clk,
    input  logic                      wt_we,
    input  logic [ROW_W-1:0]          wt_row,
    input  logic [FOLD_W-1:0]         wt_fold,
    input  logic [SIMD-1:0]           wt_bits,
    input  logic                      th_we,
    input  logic [ROW_W-1:0]          th_row,
    input  logic [CNT_W-1:0]          th_level,
    input  logic                      th_invert,
    input  logic [GRP_W-1:0]          rd_grp,
    input  logic [FOLD_W-1:0]         rd_fold,
    output logic [PE_COUNT*SIMD-1:0]  rd_bits,
    output logic [PE_COUNT*CNT_W-1:0] rd_level,
    output logic [PE_COUNT-1:0]       rd_invert
);

    logic [SIMD-1:0]  wmem [NEURONS][FOLDS];
    logic [CNT_W-1:0] tlev [NEURONS];
    logic             tinv [NEURONS];

    always_ff @(posedge clk) begin
        if (wt_we) begin
            wmem[wt_row][wt_fold] <= wt_bits;
        end
        if (th_we) begin
            tlev[th_row] <= th_level;
            tinv[th_row] <= th_invert;
        end
    end

    // PE p of group g serves neuron g*PE_COUNT + p
    for (genvar p = 0; p < PE_COUNT; p++) begin : g_port
        logic [ROW_W-1:0] row;
        assign row = ROW_W'(32'(rd_grp) * PE_COUNT + p);
        assign rd_bits[p*SIMD +: SIMD]    = wmem[row][rd_fold];
        assign rd_level[p*CNT_W +: CNT_W] = tlev[row];
        assign rd_invert[p]               = tinv[row];
    end

endmodule

// File: rtl/bnn_xnor_pe.sv
module bnn_xnor_pe
    import bnn_layer_pkg::*;
#(
    parameter int unsigned SIMD  = 8,
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  fold_step_t       step,
    input  logic [SIMD-1:0]  act,
    input  logic [SIMD-1:0]  wgt,
    input  logic [CNT_W-1:0] level,
    input  logic             invert,
    output logic             fire
);

    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] lane_pc;
    logic [CNT_W-1:0] sum;

    // agreement count of this fold: XNOR per lane, then count the ones
    always_comb begin
        lane_pc = '0;
        for (int i = 0; i < SIMD; i++) begin
            lane_pc = lane_pc + CNT_W'(~(act[i] ^ wgt[i]));
        end
    end

    assign sum  = (step.first ? '0 : acc) + lane_pc;
    assign fire = thr_fire(16'(sum), 16'(level), invert);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum;
        end
    end

endmodule

// File: rtl/bnn_seq_ctrl.sv
module bnn_seq_ctrl
    import bnn_layer_pkg::*;
#(
    parameter int unsigned FOLDS  = 4,
    parameter int unsigned GROUPS = 2,
    localparam int unsigned FOLD_W = idx_w(FOLDS),
    localparam int unsigned GRP_W  = idx_w(GROUPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              load,
    output logic              run,
    output logic [GRP_W-1:0]  grp,
    output logic [FOLD_W-1:0] fold,
    output fold_step_t        step
);

    phase_e phase;
    logic   fold_end;
    logic   grp_end;

    assign fold_end   = (fold == FOLD_W'(FOLDS - 1));
    assign grp_end    = (grp == GRP_W'(GROUPS - 1));
    assign in_ready   = (phase == PH_IDLE);
    assign out_valid  = (phase == PH_HOLD);
    assign run        = (phase == PH_RUN);
    assign load       = in_valid && in_ready;
    assign step.first = (fold == '0);
    assign step.last  = fold_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            grp   <= '0;
            fold  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (in_valid) begin
                        phase <= PH_RUN;
                        grp   <= '0;
                        fold  <= '0;
                    end
                end
                PH_RUN: begin
                    if (fold_end) begin
                        fold <= '0;
                        if (grp_end) begin
                            phase <= PH_HOLD;
                        end else begin
                            grp <= grp + 1'b1;
                        end
                    end else begin
                        fold <= fold + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (out_ready) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bnn_xnor_layer.sv
module bnn_xnor_layer
    import bnn_layer_pkg::*;
#(
    parameter int unsigned VEC_BITS = 32,
    parameter int unsigned SIMD     = 8,
    parameter int unsigned NEURONS  = 8,
    parameter int unsigned PE_COUNT = 4,
    localparam int unsigned FOLDS      = VEC_BITS / SIMD,
    localparam int unsigned GROUPS     = NEURONS / PE_COUNT,
    localparam int unsigned CNT_W      = $clog2(VEC_BITS + 1),
    localparam int unsigned ROW_W      = idx_w(NEURONS),
    localparam int unsigned FOLD_W     = idx_w(FOLDS),
    localparam int unsigned GRP_W      = idx_w(GROUPS),
    localparam int unsigned RUN_CYCLES = GROUPS * FOLDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [VEC_BITS-1:0] in_vec,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [NEURONS-1:0]  out_vec,
    input  logic                wt_we,
    input  logic [ROW_W-1:0]    wt_row,
    input  logic [FOLD_W-1:0]   wt_fold,
    input  logic [SIMD-1:0]     wt_bits,
    input  logic                th_we,
    input  logic [ROW_W-1:0]    th_row,
    input  logic [CNT_W-1:0]    th_level,
    input  logic                th_invert
);

    logic                      load;
    logic                      run;
    logic [GRP_W-1:0]          grp;
    logic [FOLD_W-1:0]         fold;
    fold_step_t                step;
    logic [PE_COUNT*SIMD-1:0]  rd_bits;
    logic [PE_COUNT*CNT_W-1:0] rd_level;
    logic [PE_COUNT-1:0]       rd_invert;
    logic [PE_COUNT-1:0]       fire;
    logic [SIMD-1:0]           act_buf [FOLDS];
    logic [PE_COUNT-1:0]       out_buf [GROUPS];

    bnn_seq_ctrl #(.FOLDS(FOLDS), .GROUPS(GROUPS)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .run       (run),
        .grp       (grp),
        .fold      (fold),
        .step      (step)
    );

    bnn_param_store #(
        .SIMD(SIMD), .NEURONS(NEURONS), .PE_COUNT(PE_COUNT),
        .FOLDS(FOLDS), .CNT_W(CNT_W)
    ) i_store (
        .clk       (clk),
        .wt_we     (wt_we),
        .wt_row    (wt_row),
        .wt_fold   (wt_fold),
        .wt_bits   (wt_bits),
        .th_we     (th_we),
        .th_row    (th_row),
        .th_level  (th_level),
        .th_invert (th_invert),
        .rd_grp    (grp),
        .rd_fold   (fold),
        .rd_bits   (rd_bits),
        .rd_level  (rd_level),
        .rd_invert (rd_invert)
    );

    // input buffer, stored fold by fold
    always_ff @(posedge clk) begin
        if (load) begin
            for (int f = 0; f < FOLDS; f++) begin
                act_buf[f] <= in_vec[f*SIMD +: SIMD];
            end
        end
    end

    for (genvar p = 0; p < PE_COUNT; p++) begin : g_pe
        bnn_xnor_pe #(.SIMD(SIMD), .CNT_W(CNT_W)) i_pe (
            .clk    (clk),
            .rst    (rst),
            .en     (run),
            .step   (step),
            .act    (act_buf[fold]),
            .wgt    (rd_bits[p*SIMD +: SIMD]),
            .level  (rd_level[p*CNT_W +: CNT_W]),
            .invert (rd_invert[p]),
            .fire   (fire[p])
        );
    end

    // output buffer: one PE-wide slot per neuron group
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < GROUPS; g++) begin
                out_buf[g] <= '0;
            end
        end else if (run && step.last) begin
            out_buf[grp] <= fire;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_out
        assign out_vec[g*PE_COUNT +: PE_COUNT] = out_buf[g];
    end

endmodule

// File: rtl/bnn_layer_checker.sv
module bnn_layer_checker #(
    parameter int unsigned RUN_CYCLES = 8,
    parameter int unsigned OUT_W      = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_vec
);

    logic [15:0] since_accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_accept <= '0;
        end else if (in_valid && in_ready) begin
            since_accept <= 16'd1;
        end else if (out_valid && out_ready) begin
            since_accept <= '0;
        end else if (since_accept != '0 && !out_valid) begin
            since_accept <= since_accept + 16'd1;
        end
    end

    AST_NO_DUAL_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R2

    AST_READY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> in_ready); // R2

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (since_accept == 16'(RUN_CYCLES + 1))); // R6

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec))); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (since_accept != '0 && !out_valid) |-> !in_ready); // R8

endmodule

bind bnn_xnor_layer bnn_layer_checker #(
    .RUN_CYCLES (RUN_CYCLES),
    .OUT_W      (NEURONS)
) i_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vec   (out_vec)
);

// File: tb/test_bnn_xnor_layer.sv
module test_bnn_xnor_layer;

    localparam int N    = 32;
    localparam int S    = 8;
    localparam int NEU  = 8;
    localparam int PEC  = 4;
    localparam int FLD  = N / S;
    localparam int LAT  = (NEU / PEC) * FLD;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic           in_ready;
    logic [N-1:0]   in_vec;
    logic           out_valid;
    logic           out_ready;
    logic [NEU-1:0] out_vec;
    logic           wt_we;
    logic [2:0]     wt_row;
    logic [1:0]     wt_fold;
    logic [S-1:0]   wt_bits;
    logic           th_we;
    logic [2:0]     th_row;
    logic [5:0]     th_level;
    logic           th_invert;

    int errors = 0;
    int checks = 0;

    logic [N-1:0] wm [NEU];
    int           lv [NEU];
    bit           iv [NEU];

    always #2 clk = ~clk;

    bnn_xnor_layer #(.VEC_BITS(N), .SIMD(S), .NEURONS(NEU), .PE_COUNT(PEC)) i_bnn_xnor_layer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec),
        .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
        .wt_we(wt_we), .wt_row(wt_row), .wt_fold(wt_fold), .wt_bits(wt_bits),
        .th_we(th_we), .th_row(th_row), .th_level(th_level), .th_invert(th_invert)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference: sign of the ±1 dot product against 2*level - N
    function automatic logic [NEU-1:0] ref_out(input logic [N-1:0] v);
        logic [NEU-1:0] r;
        for (int j = 0; j < NEU; j++) begin
            int dot = 0;
            int thr = 2 * lv[j] - N;
            for (int i = 0; i < N; i++) begin
                dot += (v[i] == wm[j][i]) ? 1 : -1;
            end
            r[j] = iv[j] ? (dot <= thr) : (dot >= thr);
        end
        return r;
    endfunction

    task automatic load_row(input int j, input logic [N-1:0] w);
        wm[j] = w;
        for (int f = 0; f < FLD; f++) begin
            @(negedge clk);
            wt_we = 1'b1; wt_row = 3'(j); wt_fold = 2'(f); wt_bits = w[f*S +: S];
        end
        @(negedge clk);
        wt_we = 1'b0;
    endtask

    task automatic set_thr(input int j, input int l, input bit inv);
        lv[j] = l; iv[j] = inv;
        @(negedge clk);
        th_we = 1'b1; th_row = 3'(j); th_level = 6'(l); th_invert = inv;
        @(negedge clk);
        th_we = 1'b0;
    endtask

    // one vector: accept, latency, result, optional busy poke and stall, drain
    task automatic do_vector(input logic [N-1:0] v, input logic [NEU-1:0] exp,
                             input int stall, input bit poke, input string req);
        bit lat_ok = 1'b1;
        bit hold_ok = 1'b1;
        logic [NEU-1:0] held;
        @(negedge clk);
        chk(in_ready === 1'b1, "R2", "in_ready before offer", 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_vec = v;
        @(posedge clk);
        @(negedge clk);
        in_valid = poke; in_vec = poke ? ~v : v;
        chk(in_ready === 1'b0, "R2", "in_ready after accept", 64'(in_ready), 64'd0);
        for (int i = 1; i <= LAT; i++) begin
            @(negedge clk);
            if (poke && in_ready !== 1'b0) lat_ok = 1'b0;
            if (out_valid !== (i == LAT)) lat_ok = 1'b0;
        end
        in_valid = 1'b0;
        chk(lat_ok, "R6", "out_valid rise edge", 64'(out_valid), 64'd1);
        chk(out_vec === exp, req, "neuron bits", 64'(out_vec), 64'(exp));
        held = out_vec;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            if (out_valid !== 1'b1 || out_vec !== held) hold_ok = 1'b0;
        end
        if (stall > 0)
            chk(hold_ok, "R7", "output held under stall", 64'(out_vec), 64'(held));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R2", "ready after drain",
            64'({in_ready, out_valid}), 64'h2);
    endtask

    task automatic t_reset();
        chk(out_valid === 1'b0, "R1", "out_valid at reset", 64'(out_valid), 64'd0);
        chk(in_ready === 1'b1, "R1", "in_ready at reset", 64'(in_ready), 64'd1);
    endtask

    task automatic t_random_layer();
        for (int j = 0; j < NEU; j++) begin
            load_row(j, $urandom());
            set_thr(j, 10 + int'($urandom_range(12)), 1'b0);
        end
        for (int k = 0; k < 4; k++) begin
            logic [N-1:0] v = $urandom();
            do_vector(v, ref_out(v), 0, 1'b0, "R3");
        end
        for (int j = 0; j < NEU; j += 2) set_thr(j, lv[j], 1'b1);
        for (int k = 0; k < 3; k++) begin
            logic [N-1:0] v = $urandom();
            do_vector(v, ref_out(v), 0, 1'b0, "R5");
        end
    endtask

    task automatic t_exact_level();
        logic [N-1:0] v = $urandom();
        for (int j = 0; j < NEU; j++)
            set_thr(j, $countones(~(v ^ wm[j])), j[0]);
        do_vector(v, {NEU{1'b1}}, 0, 1'b0, "R4");
        chk(ref_out(v) === {NEU{1'b1}}, "R4", "reference agrees", 64'(ref_out(v)), 64'hff);
        for (int j = 0; j < NEU; j++)
            set_thr(j, $countones(~(v ^ wm[j])) + (j[0] ? -1 : 1), j[0]);
        do_vector(v, {NEU{1'b0}}, 0, 1'b0, "R5");
    endtask

    task automatic t_extremes();
        load_row(3, 32'hA5C3_0F96);
        set_thr(3, N, 1'b0);
        set_thr(4, 0, 1'b0);
        set_thr(5, 0, 1'b1);
        do_vector(32'hA5C3_0F96, ref_out(32'hA5C3_0F96), 0, 1'b0, "R3");
        chk(ref_out(32'hA5C3_0F96) ==? 8'b??0_11???, "R3", "extreme pattern",
            64'(ref_out(32'hA5C3_0F96)), 64'h18);
    endtask

    task automatic t_stall_and_busy();
        logic [N-1:0] v = $urandom();
        do_vector(v, ref_out(v), 5, 1'b0, "R7");
        v = $urandom();
        do_vector(v, ref_out(v), 2, 1'b1, "R8");
        v = $urandom();
        do_vector(v, ref_out(v), 0, 1'b0, "R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_vec = '0; out_ready = 1'b0;
        wt_we = 1'b0; wt_row = '0; wt_fold = '0; wt_bits = '0;
        th_we = 1'b0; th_row = '0; th_level = '0; th_invert = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_random_layer();
        t_exact_level();
        t_extremes();
        t_stall_and_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule